// File: doc/BRIEF.md
# Host Cartridge Bus Bridge

This block sits between a console CPU's cartridge connector and the rendering core. It decodes a 16-bit address space, split evenly: the upper half (address bit 15 set) reaches a 32 KB program ROM, and the lower half is a register window. Through that window the host reads rendering status, starts a frame, streams bytes into the scene command buffer through an auto-incrementing pointer, and uses a 16×16 unsigned multiplier.

Host accesses are single-cycle strobes sampled on the rising clock edge. A read latches one byte into the data output, which then holds until the next read. Command-buffer writes and the frame start leave the block as registered one-cycle pulses, one clock after the host write.

Top module: `host_bus_bridge`

## Requirements
- R1: After reset, rdata_o, cmd_we_o and rt_start_o are 0, and the command pointer and both multiplier operands are 0.
- R2: For an address with bit 15 set, rom_addr_o equals address bits 14:0. A read strobe loads rom_data_i into rdata_o, where it is visible one cycle after the strobe.
- R3: Writes to addresses with bit 15 set have no effect: no command write, no start pulse, and no register change.
- R4: A read of 0x0000 returns status. Bit 0 is frame_busy_i, bits 2:1 are half_ready_i, and bits 7:3 are 0.
- R5: Writing 0x0000 with data bit 0 set makes rt_start_o high for exactly the next cycle. With bit 0 clear, no pulse is made.
- R6: The 12-bit command pointer is written and read at 0x0001 (bits 7:0) and at 0x0002 (bits 11:8 in data bits 3:0). Data bits 7:4 of 0x0002 are ignored on write and read as 0.
- R7: A write to 0x0003 makes cmd_we_o high for one cycle, on the next cycle, with cmd_addr_o set to the pointer value before the write and cmd_data_o set to the written byte. The pointer then increments and wraps from 0xFFF to 0x000.
- R8: Multiplier operands are written and read back as bytes: A low at 0x0010, A high at 0x0011, B low at 0x0012, B high at 0x0013.
- R9: Reads of 0x0014..0x0017 return the unsigned 32-bit product A×B, least significant byte first. The product is correct on the very next access after the last operand byte is written.
- R10: In 0x0000..0x7FFF, any address not listed above reads 0x00, and a write to it changes nothing.
- R11: rdata_o holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Host address |
| wdata_i | input | 8 | Host write data |
| rd_i | input | 1 | Host read strobe, one cycle |
| wr_i | input | 1 | Host write strobe, one cycle |
| rdata_o | output | 8 | Latched read data |
| rom_addr_o | output | 15 | Program ROM byte address |
| rom_data_i | input | 8 | Program ROM data, combinational from rom_addr_o |
| cmd_we_o | output | 1 | Command buffer write pulse |
| cmd_addr_o | output | 12 | Command buffer byte address |
| cmd_data_o | output | 8 | Command buffer write data |
| rt_start_o | output | 1 | Frame start pulse to the rendering core |
| frame_busy_i | input | 1 | Rendering core is drawing a frame |
| half_ready_i | input | 2 | One flag per frame half that is ready for transfer |

## Verification
The multiplier is tried with all-ones operands, which exercise the top product byte and every carry. It is also tried with mixed operands whose product bytes are all different, so a swapped byte lane shows up, and with a zero operand. Pointer tests write distinct low and high bytes so that a lane mix-up or a nibble leak is visible. A write at 0xFFF exposes a missing wrap. Reads and writes at window holes and in the ROM half, followed by read-back of the registers they might corrupt, tell correct decoding apart from aliasing.

// File: rtl/hbb_pkg.sv
package hbb_pkg;
  typedef enum logic [3:0] {
    SEL_NONE, SEL_ROM, SEL_STAT, SEL_PTR_LO, SEL_PTR_HI, SEL_CMD,
    SEL_A_LO, SEL_A_HI, SEL_B_LO, SEL_B_HI,
    SEL_P0, SEL_P1, SEL_P2, SEL_P3
  } reg_sel_e;

  localparam int unsigned WIN_OFS_W = 5;
endpackage

// File: rtl/hbb_decode.sv
module hbb_decode
  import hbb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  localparam int unsigned HOLE_W = ADDR_W - 1 - WIN_OFS_W;

  logic [HOLE_W-1:0]    upper;
  logic [WIN_OFS_W-1:0] ofs;

  assign upper = addr_i[ADDR_W-2:WIN_OFS_W];
  assign ofs   = addr_i[WIN_OFS_W-1:0];

  always_comb begin
    sel_o = SEL_NONE;
    if (addr_i[ADDR_W-1]) begin
      sel_o = SEL_ROM;
    end else if (upper == '0) begin
      case (ofs)
        5'h00:   sel_o = SEL_STAT;
        5'h01:   sel_o = SEL_PTR_LO;
        5'h02:   sel_o = SEL_PTR_HI;
        5'h03:   sel_o = SEL_CMD;
        5'h10:   sel_o = SEL_A_LO;
        5'h11:   sel_o = SEL_A_HI;
        5'h12:   sel_o = SEL_B_LO;
        5'h13:   sel_o = SEL_B_HI;
        5'h14:   sel_o = SEL_P0;
        5'h15:   sel_o = SEL_P1;
        5'h16:   sel_o = SEL_P2;
        5'h17:   sel_o = SEL_P3;
        default: sel_o = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/hbb_cmd_port.sv
module hbb_cmd_port #(
  parameter int unsigned CMD_AW = 12,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ptr_lo_we_i,
  input  logic              ptr_hi_we_i,
  input  logic              data_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CMD_AW-1:0] ptr_o,
  output logic              cmd_we_o,
  output logic [CMD_AW-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o
);
  localparam int unsigned HI_W = CMD_AW - DATA_W;

  logic [CMD_AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      cmd_we_o   <= 1'b0;
      cmd_addr_o <= '0;
      cmd_data_o <= '0;
    end else begin
      cmd_we_o <= data_we_i;
      if (data_we_i) begin
        cmd_addr_o <= ptr_q;
        cmd_data_o <= wdata_i;
        ptr_q      <= ptr_q + 1'b1;
      end else if (ptr_lo_we_i) begin
        ptr_q[DATA_W-1:0] <= wdata_i;
      end else if (ptr_hi_we_i) begin
        ptr_q[CMD_AW-1:DATA_W] <= wdata_i[HI_W-1:0];
      end
    end
  end

  assign ptr_o = ptr_q;

  a_r7_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_we_i |=> (ptr_q == $past(ptr_q) + 1'b1));
  a_r7_we_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_o |-> $past(data_we_i));
endmodule

// File: rtl/hbb_mul.sv
module hbb_mul #(
  parameter int unsigned OP_W   = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*OP_W/DATA_W-1:0] we_i,   // A lanes low..high, then B lanes
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [OP_W-1:0]     opa_o,
  output logic [OP_W-1:0]     opb_o,
  output logic [2*OP_W-1:0]   prod_o
);
  localparam int unsigned NB = OP_W / DATA_W;

  logic [DATA_W-1:0] a_q [NB];
  logic [DATA_W-1:0] b_q [NB];

  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) a_q[i] <= '0;
      else if (we_i[i]) a_q[i] <= wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) b_q[i] <= '0;
      else if (we_i[NB+i]) b_q[i] <= wdata_i;
    end
    assign opa_o[i*DATA_W +: DATA_W] = a_q[i];
    assign opb_o[i*DATA_W +: DATA_W] = b_q[i];
  end

  // combinational so the product is ready on the access right after the last write
  assign prod_o = (2*OP_W)'(opa_o) * (2*OP_W)'(opb_o);

  a_r8_ops_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i == '0) |=> ($stable(opa_o) && $stable(opb_o)));
endmodule

// File: rtl/host_bus_bridge.sv
module host_bus_bridge
  import hbb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CMD_AW = 12,
  parameter int unsigned OP_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic              wr_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-2:0] rom_addr_o,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic              cmd_we_o,
  output logic [CMD_AW-1:0] cmd_addr_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              rt_start_o,
  input  logic              frame_busy_i,
  input  logic [1:0]        half_ready_i
);
  localparam int unsigned NB   = OP_W / DATA_W;
  localparam int unsigned HI_W = CMD_AW - DATA_W;

  reg_sel_e             sel;
  logic [CMD_AW-1:0]    ptr;
  logic [2*NB-1:0]      mul_we;
  logic [OP_W-1:0]      opa, opb;
  logic [2*OP_W-1:0]    prod;
  logic [DATA_W-1:0]    rd_mux;
  logic [DATA_W-1:0]    rdata_q;
  logic                 start_q;

  hbb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  hbb_cmd_port #(.CMD_AW(CMD_AW), .DATA_W(DATA_W)) u_cmd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ptr_lo_we_i (wr_i && sel == SEL_PTR_LO),
    .ptr_hi_we_i (wr_i && sel == SEL_PTR_HI),
    .data_we_i   (wr_i && sel == SEL_CMD),
    .wdata_i     (wdata_i),
    .ptr_o       (ptr),
    .cmd_we_o    (cmd_we_o),
    .cmd_addr_o  (cmd_addr_o),
    .cmd_data_o  (cmd_data_o)
  );

  assign mul_we = {wr_i && sel == SEL_B_HI, wr_i && sel == SEL_B_LO,
                   wr_i && sel == SEL_A_HI, wr_i && sel == SEL_A_LO};

  hbb_mul #(.OP_W(OP_W), .DATA_W(DATA_W)) u_mul (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mul_we),
    .wdata_i (wdata_i),
    .opa_o   (opa),
    .opb_o   (opb),
    .prod_o  (prod)
  );

  assign rom_addr_o = addr_i[ADDR_W-2:0];

  always_comb begin
    case (sel)
      SEL_ROM:    rd_mux = rom_data_i;
      SEL_STAT:   rd_mux = {{(DATA_W-3){1'b0}}, half_ready_i, frame_busy_i};
      SEL_PTR_LO: rd_mux = ptr[DATA_W-1:0];
      SEL_PTR_HI: rd_mux = {{(DATA_W-HI_W){1'b0}}, ptr[CMD_AW-1:DATA_W]};
      SEL_A_LO:   rd_mux = opa[DATA_W-1:0];
      SEL_A_HI:   rd_mux = opa[OP_W-1:DATA_W];
      SEL_B_LO:   rd_mux = opb[DATA_W-1:0];
      SEL_B_HI:   rd_mux = opb[OP_W-1:DATA_W];
      SEL_P0:     rd_mux = prod[0*DATA_W +: DATA_W];
      SEL_P1:     rd_mux = prod[1*DATA_W +: DATA_W];
      SEL_P2:     rd_mux = prod[2*DATA_W +: DATA_W];
      SEL_P3:     rd_mux = prod[3*DATA_W +: DATA_W];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      start_q <= 1'b0;
    end else begin
      if (rd_i) rdata_q <= rd_mux;
      start_q <= wr_i && (sel == SEL_STAT) && wdata_i[0];
    end
  end

  assign rdata_o    = rdata_q;
  assign rt_start_o = start_q;

  a_r3_rom_write_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i[ADDR_W-1]) |=> (!cmd_we_o && !rt_start_o));
  a_r5_start_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rt_start_o |-> ($past(wr_i) && $past(addr_i) == '0));
  a_r11_rdata_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(rdata_o));
  a_r4_status_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == '0) |=> (rdata_o[DATA_W-1:3] == '0));
endmodule

// File: tb/tb_host_bus_bridge.sv
`timescale 1ns/1ps
module tb_host_bus_bridge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd = 1'b0, wr = 1'b0;
  logic [7:0]  rdata;
  logic [14:0] rom_addr;
  logic [7:0]  rom_data;
  logic        cmd_we;
  logic [11:0] cmd_addr;
  logic [7:0]  cmd_data;
  logic        rt_start;
  logic        busy = 1'b1;
  logic [1:0]  half = 2'b10;

  int errors = 0, checks = 0;
  int n_cmd = 0, n_start = 0;
  logic [11:0] last_cmd_addr;
  logic [7:0]  last_cmd_data;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] rom_f(logic [14:0] a);
    return a[7:0] ^ a[14:7];
  endfunction
  assign rom_data = rom_f(rom_addr);

  host_bus_bridge dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
    .rd_i(rd), .wr_i(wr), .rdata_o(rdata), .rom_addr_o(rom_addr),
    .rom_data_i(rom_data), .cmd_we_o(cmd_we), .cmd_addr_o(cmd_addr),
    .cmd_data_o(cmd_data), .rt_start_o(rt_start),
    .frame_busy_i(busy), .half_ready_i(half)
  );

  always @(posedge clk) begin
    if (cmd_we) begin
      n_cmd <= n_cmd + 1;
      last_cmd_addr <= cmd_addr;
      last_cmd_data <= cmd_data;
    end
    if (rt_start) n_start <= n_start + 1;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [15:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [15:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // {req[3:0], is_write, addr[15:0], data_or_expected[7:0]}
  localparam int NV = 30;
  localparam logic [28:0] VEC [NV] = '{
    {4'd4, 1'b0, 16'h0000, 8'h05},  // R4 status
    {4'd6, 1'b1, 16'h0001, 8'h34},  // R6
    {4'd6, 1'b1, 16'h0002, 8'hA5},
    {4'd6, 1'b0, 16'h0002, 8'h05},
    {4'd6, 1'b0, 16'h0001, 8'h34},
    {4'd8, 1'b1, 16'h0010, 8'hFF},  // R8 / R9 all ones
    {4'd8, 1'b1, 16'h0011, 8'hFF},
    {4'd8, 1'b1, 16'h0012, 8'hFF},
    {4'd8, 1'b1, 16'h0013, 8'hFF},
    {4'd9, 1'b0, 16'h0014, 8'h01},
    {4'd9, 1'b0, 16'h0015, 8'h00},
    {4'd9, 1'b0, 16'h0016, 8'hFE},
    {4'd9, 1'b0, 16'h0017, 8'hFF},
    {4'd8, 1'b0, 16'h0010, 8'hFF},
    {4'd8, 1'b1, 16'h0010, 8'h34},  // mixed operands
    {4'd8, 1'b1, 16'h0011, 8'h12},
    {4'd8, 1'b1, 16'h0012, 8'h10},
    {4'd8, 1'b1, 16'h0013, 8'h00},
    {4'd9, 1'b0, 16'h0014, 8'h40},
    {4'd9, 1'b0, 16'h0015, 8'h23},
    {4'd9, 1'b0, 16'h0016, 8'h01},
    {4'd9, 1'b0, 16'h0017, 8'h00},
    {4'd8, 1'b0, 16'h0011, 8'h12},
    {4'd8, 1'b0, 16'h0012, 8'h10},
    {4'd10, 1'b0, 16'h0020, 8'h00}, // R10 holes
    {4'd10, 1'b0, 16'h7FFF, 8'h00},
    {4'd10, 1'b0, 16'h0005, 8'h00},
    {4'd10, 1'b1, 16'h0005, 8'hAA},
    {4'd10, 1'b1, 16'h0110, 8'hBB},
    {4'd10, 1'b0, 16'h0010, 8'h34}
  };

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int nc, ns;
    idle(3);
    // R1 reset state
    chk("R1 rdata", {24'h0, rdata}, 32'h0);
    chk("R1 cmd_we", {31'h0, cmd_we}, 32'h0);
    chk("R1 start", {31'h0, rt_start}, 32'h0);
    rst_n = 1'b1;
    bus_rd(16'h0001, d); chk("R1 ptr", {24'h0, d}, 32'h0);
    bus_rd(16'h0013, d); chk("R1 opb", {24'h0, d}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [28:0] v;
      v = VEC[i];
      if (v[24]) bus_wr(v[23:8], v[7:0]);
      else begin
        bus_rd(v[23:8], d);
        checks++;
        if (d !== v[7:0]) begin
          errors++;
          $display("FAIL R%0d vec %0d: actual=%h expected=%h", v[28:25], i, d, v[7:0]);
        end
      end
    end

    // R9 zero operand, product read immediately after last write
    bus_wr(16'h0010, 8'h00); bus_wr(16'h0011, 8'h00);
    bus_wr(16'h0012, 8'hCD); bus_wr(16'h0013, 8'hAB);
    bus_rd(16'h0016, d); chk("R9 zero product", {24'h0, d}, 32'h0);

    // R7 command write at pointer 0x534
    nc = n_cmd;
    bus_wr(16'h0003, 8'h77); idle(1);
    chk("R7 pulse count", n_cmd - nc, 1);
    chk("R7 addr", {20'h0, last_cmd_addr}, 32'h534);
    chk("R7 data", {24'h0, last_cmd_data}, 32'h77);
    bus_rd(16'h0001, d); chk("R7 ptr incr", {24'h0, d}, 32'h35);
    // R7 wrap
    bus_wr(16'h0001, 8'hFF); bus_wr(16'h0002, 8'h0F);
    bus_wr(16'h0003, 8'h3C); idle(1);
    chk("R7 wrap addr", {20'h0, last_cmd_addr}, 32'hFFF);
    bus_rd(16'h0001, d); chk("R7 wrap lo", {24'h0, d}, 32'h0);
    bus_rd(16'h0002, d); chk("R7 wrap hi", {24'h0, d}, 32'h0);

    // R5 start pulse
    ns = n_start;
    bus_wr(16'h0000, 8'h01); chk("R5 pulse high", {31'h0, rt_start}, 32'h1);
    idle(1); chk("R5 pulse width", {31'h0, rt_start}, 32'h0);
    chk("R5 count", n_start - ns, 1);
    bus_wr(16'h0000, 8'h02); idle(1);
    chk("R5 bit0 clear", n_start - ns, 1);

    // R3 ROM-half writes
    nc = n_cmd; ns = n_start;
    bus_wr(16'h8003, 8'h99); bus_wr(16'h8000, 8'h01);
    bus_wr(16'h8010, 8'h55); bus_wr(16'h8001, 8'h44); idle(1);
    chk("R3 no cmd", n_cmd - nc, 0);
    chk("R3 no start", n_start - ns, 0);
    bus_rd(16'h0010, d); chk("R3 opa kept", {24'h0, d}, 32'h0);
    bus_rd(16'h0001, d); chk("R3 ptr kept", {24'h0, d}, 32'h0);

    // R2 ROM reads
    bus_rd(16'h8123, d);
    chk("R2 rom addr", {17'h0, rom_addr}, 32'h0123);
    chk("R2 rom data", {24'h0, d}, {24'h0, rom_f(15'h0123)});
    bus_rd(16'hFFFF, d); chk("R2 rom top", {24'h0, d}, {24'h0, rom_f(15'h7FFF)});

    // R4 status with other inputs
    busy = 1'b0; half = 2'b01;
    bus_rd(16'h0000, d); chk("R4 status", {24'h0, d}, 32'h02);

    // R11 hold without read
    @(negedge clk); addr = 16'h8055;
    idle(3); chk("R11 hold", {24'h0, rdata}, 32'h02);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule